// File: doc/BRIEF.md
# Wavetable DMA Transfer Controller

This block sits on the local-memory side of a system DMA channel and moves sample data between that channel and a local wavetable memory. Software sets up a transfer by writing three things: a start register that holds a 16-byte-granular base, an extension register whose low nibble refines that base to the byte, and a control register. The control register sets the direction, selects sign-bit inversion for 8-bit samples, enables the end-of-block interrupt and raises the request. Bytes then move one at a time over a valid/ready handshake. System-to-local traffic comes in on the inbound port and is written to memory. Local-to-system traffic is read from memory and presented on the outbound port.

On an 8-bit channel each byte goes to the next linear address. On a 16-bit channel the base goes through a banked, doubled translation, and each sample occupies a low byte and then a high byte at consecutive addresses. When the system side flags terminal count on the last sample, the block drops its request and advances the start and extension registers past the block. If the interrupt is enabled, it also latches a pending flag that drives the interrupt line. Reading the control register reports the channel width and the pending flag, and that read clears both the flag and two control bits.

Top module: `wt_dma_ctrl`

## Requirements
- R1: After reset, sys_req, irq, mem_wr_en and mem_rd_en are 0, and an unstrobed view of the control register (reg_sel 0) on an 8-bit channel reads 0.
- R2: A control write (reg_sel 0) with bit 0 set raises sys_req. With control bit 1 = 0, sys_in_ready is 1 and sys_out_valid is 0. With bit 1 = 1, the two are the other way round.
- R3: On an 8-bit channel (wide_chan 0), the k-th byte of a block goes to mem_addr = start×16 + ext[3:0] + k. The block restarts at k = 0 on each control write.
- R4: On a 16-bit channel, with off = start×16 + ext[3:0], the base is T = (off & 0xC0000) + 2×(off & 0x1FFF0). Sample k writes its low byte at T+2k and its high byte at T+2k+1.
- R5: In the system-to-local direction with control bit 7 set, bit 7 of each byte written is inverted. When control bit 6 is set, the 8-bit sample (or the low byte of a 16-bit sample) passes unchanged. The high byte of a 16-bit sample is still inverted.
- R6: With control bit 1 = 1, each outbound byte is mem_rdata unchanged, whatever bit 7 holds. mem_rd_en is high and mem_wr_en stays low.
- R7: A handshake that completes a sample while sys_tc is high ends the block. Control bit 0 and sys_req clear. The start register advances by N>>4, where N is the number of samples in the block. Extension bits 3:0 become (N + old) mod 16, and bits 7:4 keep their value.
- R8: At the end of a block, if control bit 5 is set, irq rises and stays high until the control register is read. If bit 5 is clear, irq stays low.
- R9: A strobed control read (reg_rd_en with reg_sel 0) returns the stored control value with bit 2 set on a 16-bit channel and bit 6 set if the interrupt was pending. After the read, irq is low and control bits 6 and 2 are 0.
- R10: A write to the start register (reg_sel 1) clears extension bits 7:4. The extension register (reg_sel 2) reads back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_chan | input | 1 | 1 when the system channel is 16-bit |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (side effects on control read) |
| reg_sel | input | 2 | 0 control, 1 start, 2 extension |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| sys_req | output | 1 | Transfer request to the system DMA side |
| sys_tc | input | 1 | Terminal count, qualifies the final sample's handshake |
| sys_in_valid | input | 1 | Inbound byte valid |
| sys_in_ready | output | 1 | Inbound byte accepted |
| sys_in_data | input | 8 | Inbound byte |
| sys_out_valid | output | 1 | Outbound byte valid |
| sys_out_ready | input | 1 | Outbound byte taken |
| sys_out_data | output | 8 | Outbound byte |
| mem_addr | output | 20 | Local memory byte address |
| mem_wr_en | output | 1 | Local memory write |
| mem_wdata | output | 8 | Local memory write data |
| mem_rd_en | output | 1 | Local memory read |
| mem_rdata | input | 8 | Local memory read data (same cycle) |
| irq | output | 1 | Interrupt, high while the end-of-block flag is pending |

## Verification
The hardest state to reach from the ports is a pending interrupt on a 16-bit channel while control bit 6 is still set. Only there does the control read show both of its added bits, and only there does clearing bit 6 visibly change the stored value. The stimulus reaches it by running a complete 16-bit block with inversion, raw low byte and interrupt enable all set, ending it with terminal count on a high byte. It then holds irq for several cycles before issuing two control reads. A 20-sample block pushes the sample count past 16, so the start register advances and the extension nibble wraps.

// File: rtl/wt_dma_pkg.sv
package wt_dma_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_START = 2'd1,
      SEL_EXT   = 2'd2
   } reg_sel_e;

   localparam int CB_REQ  = 0;
   localparam int CB_DIR  = 1;
   localparam int CB_WIDE = 2;
   localparam int CB_TCIE = 5;
   localparam int CB_RAW  = 6;
   localparam int CB_INV  = 7;
endpackage

// File: rtl/wt_dma_addr.sv
module wt_dma_addr #(
   parameter int START_W   = 16,
   parameter int CNT_W     = 16,
   parameter int BANK_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [START_W-1:0]   start,
   input  logic [3:0]           ext_lo,
   input  logic                 wide,
   input  logic [CNT_W-1:0]     cnt,
   input  logic                 hi,
   output logic [START_W+3:0]   addr
);
   localparam int ADDR_W = START_W + 4;
   localparam int IN_W   = ADDR_W - BANK_BITS - 5;

   if (IN_W < 1) begin : g_bad_bank
      $error("BANK_BITS leaves no in-bank field");
   end
   if (CNT_W >= ADDR_W) begin : g_bad_cnt
      $error("CNT_W must be narrower than the address");
   end

   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] wbase;

   assign off = {start, ext_lo};

   if (BANK_BITS > 0) begin : g_bank
      assign wbase = {off[ADDR_W-1 -: BANK_BITS], off[IN_W+3:4], 5'b0};
   end else begin : g_flat
      assign wbase = {off[IN_W+3:4], 5'b0};
   end

   always_comb begin
      if (wide) addr = wbase + ADDR_W'({cnt, 1'b0}) + ADDR_W'(hi);
      else      addr = off + ADDR_W'(cnt);
   end

   // R4
   wide_lo_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wide && !hi) |-> !addr[0]);
endmodule

// File: rtl/wt_dma_conv.sv
module wt_dma_conv #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              inv_en,
   input  logic              raw_mode,
   input  logic              hi,
   output logic [DATA_W-1:0] cooked
);
   logic [DATA_W-1:0] sign_mask;

   assign sign_mask = {inv_en, {(DATA_W-1){1'b0}}};

   always_comb begin
      if (hi || !raw_mode) cooked = raw ^ sign_mask;
      else                 cooked = raw;
   end
endmodule

// File: rtl/wt_dma_ctrl.sv
module wt_dma_ctrl
   import wt_dma_pkg::*;
#(
   parameter int START_W   = 16,
   parameter int CNT_W     = 16,
   parameter int BANK_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wide_chan,
   input  logic                 reg_wr_en,
   input  logic                 reg_rd_en,
   input  logic [1:0]           reg_sel,
   input  logic [START_W-1:0]   reg_wdata,
   output logic [START_W-1:0]   reg_rdata,
   output logic                 sys_req,
   input  logic                 sys_tc,
   input  logic                 sys_in_valid,
   output logic                 sys_in_ready,
   input  logic [7:0]           sys_in_data,
   output logic                 sys_out_valid,
   input  logic                 sys_out_ready,
   output logic [7:0]           sys_out_data,
   output logic [START_W+3:0]   mem_addr,
   output logic                 mem_wr_en,
   output logic [7:0]           mem_wdata,
   output logic                 mem_rd_en,
   input  logic [7:0]           mem_rdata,
   output logic                 irq
);
   localparam int PAD_W = START_W - 8;

   if (START_W <= 8) begin : g_bad_start
      $error("START_W must exceed 8");
   end

   logic [7:0]         ctrl_q;
   logic [START_W-1:0] start_q;
   logic [7:0]         ext_q;
   logic               pend_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               hi_q;

   logic dir, beat, sample_end, done;
   logic ctrl_wr, start_wr, ext_wr, rd_ctrl;
   logic [CNT_W-1:0] n_total;

   assign dir        = ctrl_q[CB_DIR];
   assign sys_req    = ctrl_q[CB_REQ];
   assign sys_in_ready  = ctrl_q[CB_REQ] && !dir;
   assign sys_out_valid = ctrl_q[CB_REQ] && dir;
   assign mem_rd_en     = sys_out_valid;
   assign mem_wr_en     = sys_in_valid && sys_in_ready;
   assign sys_out_data  = mem_rdata;
   assign beat       = dir ? (sys_out_valid && sys_out_ready) : mem_wr_en;
   assign sample_end = beat && (!wide_chan || hi_q);
   assign done       = sample_end && sys_tc;
   assign n_total    = cnt_q + 1'b1;
   assign irq        = pend_q;

   assign ctrl_wr  = reg_wr_en && (reg_sel == SEL_CTRL);
   assign start_wr = reg_wr_en && (reg_sel == SEL_START);
   assign ext_wr   = reg_wr_en && (reg_sel == SEL_EXT);
   assign rd_ctrl  = reg_rd_en && (reg_sel == SEL_CTRL);

   wt_dma_addr #(.START_W(START_W), .CNT_W(CNT_W), .BANK_BITS(BANK_BITS)) addr_i (
      .clk(clk), .rst_n(rst_n), .start(start_q), .ext_lo(ext_q[3:0]),
      .wide(wide_chan), .cnt(cnt_q), .hi(hi_q), .addr(mem_addr));

   wt_dma_conv #(.DATA_W(8)) conv_i (
      .raw(sys_in_data), .inv_en(ctrl_q[CB_INV] && !dir),
      .raw_mode(ctrl_q[CB_RAW]), .hi(hi_q), .cooked(mem_wdata));

   always_comb begin
      case (reg_sel)
         SEL_CTRL:  reg_rdata = {{PAD_W{1'b0}}, ctrl_q | {1'b0, pend_q, 3'b0, wide_chan, 2'b0}};
         SEL_START: reg_rdata = start_q;
         SEL_EXT:   reg_rdata = {{PAD_W{1'b0}}, ext_q};
         default:   reg_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         start_q <= '0;
         ext_q   <= '0;
         pend_q  <= 1'b0;
         cnt_q   <= '0;
         hi_q    <= 1'b0;
      end else begin
         if (beat) hi_q <= wide_chan && !hi_q;
         if (sample_end) cnt_q <= n_total;
         if (rd_ctrl) begin
            pend_q          <= 1'b0;
            ctrl_q[CB_RAW]  <= 1'b0;
            ctrl_q[CB_WIDE] <= 1'b0;
         end
         if (done) begin
            ctrl_q[CB_REQ] <= 1'b0;
            start_q        <= start_q + START_W'(n_total >> 4);
            ext_q[3:0]     <= ext_q[3:0] + n_total[3:0];
            cnt_q          <= '0;
            hi_q           <= 1'b0;
            if (ctrl_q[CB_TCIE]) pend_q <= 1'b1;
         end
         if (ctrl_wr) begin
            ctrl_q <= reg_wdata[7:0];
            cnt_q  <= '0;
            hi_q   <= 1'b0;
         end
         if (start_wr) begin
            start_q    <= reg_wdata;
            ext_q[7:4] <= 4'h0;
         end
         if (ext_wr) ext_q <= reg_wdata[7:0];
      end
   end

   // R2
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && reg_wdata[CB_REQ]) |=> sys_req);
   // R6
   dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_en && mem_rd_en));
   // R7
   tc_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ctrl_wr) |=> !sys_req);
   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_ctrl) |=> irq);
   // R9
   rd_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && !done) |=> !irq);
   // R10
   start_wr_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && !ext_wr) |=> (ext_q[7:4] == 4'h0));
endmodule

// File: tb/wt_dma_ctrl_tb.sv
module wt_dma_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_chan = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sys_req, sys_tc = 1'b0;
   logic        sys_in_valid = 1'b0, sys_in_ready;
   logic [7:0]  sys_in_data = '0;
   logic        sys_out_valid, sys_out_ready = 1'b0;
   logic [7:0]  sys_out_data;
   logic [19:0] mem_addr;
   logic        mem_wr_en, mem_rd_en;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        irq;

   int total = 0, fails = 0;
   logic [19:0] cap_addr;
   logic [7:0]  cap_data;
   logic        cap_we;
   logic [15:0] rv;

   always #4 clk = ~clk;

   wt_dma_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wide_chan(wide_chan),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sys_req(sys_req), .sys_tc(sys_tc),
      .sys_in_valid(sys_in_valid), .sys_in_ready(sys_in_ready), .sys_in_data(sys_in_data),
      .sys_out_valid(sys_out_valid), .sys_out_ready(sys_out_ready), .sys_out_data(sys_out_data),
      .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
      .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .irq(irq));

   typedef struct packed {
      logic [15:0] start;
      logic [7:0]  ext;
      logic [7:0]  ctrl;
      logic [7:0]  din;
      logic [19:0] exp_addr;
      logic [7:0]  exp_data;
      logic [7:0]  exp_ext;
   } vec_t;

   localparam vec_t VEC [0:3] = '{
      '{16'h0010, 8'h53, 8'h01, 8'h85, 20'h00103, 8'h85, 8'h54},
      '{16'h1234, 8'h0F, 8'h81, 8'h12, 20'h1234F, 8'h92, 8'h00},
      '{16'hFFFF, 8'h0A, 8'hC1, 8'hF0, 20'hFFFFA, 8'hF0, 8'h0B},
      '{16'h0000, 8'h00, 8'h81, 8'h80, 20'h00000, 8'h00, 8'h01}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] sel, output logic [15:0] v);
      @(negedge clk);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   task automatic rd_ctrl(output logic [15:0] v);
      @(negedge clk);
      reg_rd_en = 1'b1; reg_sel = 2'd0;
      #1 v = reg_rdata;
      @(posedge clk); #1;
      reg_rd_en = 1'b0;
   endtask

   task automatic push(input logic [7:0] d, input logic tc);
      @(negedge clk);
      sys_in_valid = 1'b1; sys_in_data = d; sys_tc = tc;
      #1;
      cap_addr = mem_addr; cap_data = mem_wdata; cap_we = mem_wr_en;
      @(posedge clk); #1;
      sys_in_valid = 1'b0; sys_tc = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      #1;
      chk("R1 sys_req", sys_req, 0);
      chk("R1 irq", irq, 0);
      chk("R1 mem_wr_en", mem_wr_en, 0);
      chk("R1 mem_rd_en", mem_rd_en, 0);
      chk("R1 ctrl view", reg_rdata, 16'h0000);
      rst_n = 1'b1;

      // R3 R5 R7 R8: vector table, one-sample 8-bit blocks
      for (int i = 0; i < 4; i++) begin
         wr(2'd1, VEC[i].start);
         wr(2'd2, {8'h00, VEC[i].ext});
         wr(2'd0, {8'h00, VEC[i].ctrl});
         push(VEC[i].din, 1'b1);
         chk("R3 vec addr", cap_addr, VEC[i].exp_addr);
         chk("R5 vec data", cap_data, VEC[i].exp_data);
         chk("R3 vec write", cap_we, 1);
         #1 chk("R7 vec req cleared", sys_req, 0);
         chk("R8 vec no irq", irq, 0);
         peek(2'd2, rv);
         chk("R7 vec ext", rv, {8'h00, VEC[i].exp_ext});
         peek(2'd1, rv);
         chk("R7 vec start", rv, VEC[i].start);
      end

      // R2 R3 R7: 20-sample 8-bit block
      wr(2'd1, 16'h0100);
      wr(2'd2, 16'h000E);
      wr(2'd0, 16'h0001);
      chk("R2 req", sys_req, 1);
      chk("R2 in_ready", sys_in_ready, 1);
      chk("R2 out_valid", sys_out_valid, 0);
      for (int k = 0; k < 20; k++) begin
         push(8'(k), k == 19);
         chk("R3 block addr", cap_addr, 20'h0100E + 20'(k));
      end
      peek(2'd1, rv);
      chk("R7 start advance", rv, 16'h0101);
      peek(2'd2, rv);
      chk("R7 ext wrap", rv, 16'h0002);

      // R4 R5: 16-bit block with inversion
      @(negedge clk); wide_chan = 1'b1;
      wr(2'd1, 16'h4123);
      wr(2'd2, 16'h0005);
      wr(2'd0, 16'h0081);
      push(8'h11, 1'b0);
      chk("R4 lo0 addr", cap_addr, 20'h42460);
      chk("R5 lo0 data", cap_data, 8'h91);
      push(8'h22, 1'b0);
      chk("R4 hi0 addr", cap_addr, 20'h42461);
      chk("R5 hi0 data", cap_data, 8'hA2);
      push(8'h33, 1'b0);
      chk("R4 lo1 addr", cap_addr, 20'h42462);
      chk("R5 lo1 data", cap_data, 8'hB3);
      push(8'h44, 1'b1);
      chk("R4 hi1 addr", cap_addr, 20'h42463);
      chk("R5 hi1 data", cap_data, 8'hC4);
      chk("R7 wide req cleared", sys_req, 0);
      peek(2'd2, rv);
      chk("R7 wide ext", rv, 16'h0007);

      // R5 R8 R9: raw low byte, TC interrupt, read-to-clear
      wr(2'd0, 16'h00E1);
      push(8'h11, 1'b0);
      chk("R5 raw lo addr", cap_addr, 20'h42460);
      chk("R5 raw lo data", cap_data, 8'h11);
      push(8'h22, 1'b1);
      chk("R5 raw hi data", cap_data, 8'hA2);
      chk("R8 irq raised", irq, 1);
      repeat (5) @(negedge clk);
      #1 chk("R8 irq held", irq, 1);
      rd_ctrl(rv);
      chk("R9 first read", rv, 16'h00E4);
      chk("R9 irq cleared", irq, 0);
      rd_ctrl(rv);
      chk("R9 second read", rv, 16'h00A4);

      // R2 R6: local-to-system, inversion ignored
      @(negedge clk); wide_chan = 1'b0; mem_rdata = 8'hC5;
      wr(2'd1, 16'h0200);
      wr(2'd2, 16'h0001);
      wr(2'd0, 16'h0083);
      chk("R2 out req", sys_req, 1);
      chk("R2 out in_ready", sys_in_ready, 0);
      chk("R2 out valid", sys_out_valid, 1);
      @(negedge clk);
      sys_out_ready = 1'b1; sys_tc = 1'b1;
      #1;
      chk("R6 out data", sys_out_data, 8'hC5);
      chk("R6 out addr", mem_addr, 20'h02001);
      chk("R6 rd_en", mem_rd_en, 1);
      chk("R6 no write", mem_wr_en, 0);
      @(posedge clk); #1;
      sys_out_ready = 1'b0; sys_tc = 1'b0;
      chk("R7 out req cleared", sys_req, 0);
      peek(2'd2, rv);
      chk("R7 out ext", rv, 16'h0002);

      // R10: start write clears extension high nibble
      wr(2'd2, 16'h00F3);
      peek(2'd2, rv);
      chk("R10 ext full readback", rv, 16'h00F3);
      wr(2'd1, 16'h0005);
      peek(2'd2, rv);
      chk("R10 ext high cleared", rv, 16'h0003);

      report();
   end
endmodule